// File: doc/BRIEF.md
# Signed Sample Accumulator with Selectable Negative Handling

This block keeps a running total of signed conversion results from a current-measurement channel. Each result arrives as a signed 16-bit value, marked by a one-cycle valid strobe, and is folded into a 32-bit total register. A 2-bit mode input sets how the total behaves. One mode switches the accumulator off and holds it at zero. Another floors the total at zero whenever a negative sample would take it lower. A third treats the total as a two's-complement signed value that can go negative and wraps freely. The fourth works like the third and also compares the total against a threshold.

The comparator raises a single-cycle interrupt pulse the first time the signed total reaches or passes the signed threshold. It arms again only after the total has dropped back below the threshold. Register access, the converter and the interrupt controller sit outside this block.

Top module: `sample_accum`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge, the total becomes 0 and `cmp_irq` becomes 0.
- R2: With mode 2'b00 the total is 0 after the next clock edge and stays 0 whatever the strobe and sample inputs do; `cmp_irq` stays 0.
- R3: With mode 2'b01 a strobed sample that is zero or positive is added to the total (unsigned, modulo 2^32). A strobed negative sample has its magnitude subtracted. If the magnitude exceeds the current total, the total becomes 0.
- R4: With mode 2'b10 a strobed sample, sign-extended, is added to the total as a two's-complement value modulo 2^32. The total may become negative, and it wraps past 0x7FFFFFFF into negative values with no saturation.
- R5: With mode 2'b11 the total is updated exactly as in mode 2'b10.
- R6: In mode 2'b11 with the comparator armed, `cmp_irq` is high for exactly one cycle, in the cycle after a clock edge at which the registered total, read as signed, is greater than or equal to `threshold`, also read as signed. Outside mode 2'b11 `cmp_irq` is 0.
- R7: After a pulse the comparator gives no further pulse while the total stays at or above the threshold. It re-arms at an edge where the total is below the threshold, or at any edge where the mode is not 2'b11.
- R8: The total changes on the clock edge that samples `smp_valid` high and is visible after that edge. With `smp_valid` low in a non-zero mode the total holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | One-cycle strobe marking a new sample |
| smp_data | input | 16 | Signed two's-complement conversion result |
| mode | input | 2 | 00 off, 01 floored, 10 signed, 11 signed with comparator |
| threshold | input | 32 | Signed comparator threshold |
| acc_total | output | 32 | Registered running total |
| cmp_irq | output | 1 | Single-cycle comparator interrupt pulse |

## Verification
A wrong total shows up on `acc_total` one edge after the strobe that caused it, because the total is the only state the output reads. The error then carries into every later value, so a single bad floor or wrap keeps the bench's running model off from that cycle on. A stuck or wrong arm flag shows on `cmp_irq` within one cycle of the next threshold crossing, either as a missing pulse or as a second pulse. The sweeps cross the threshold in both directions and switch modes to expose these cases.

// File: rtl/sacc_pkg.sv
`timescale 1ns/1ps
// Package: shared mode encoding for the sample accumulator.
// Assumes a 2-bit mode field whose values the register bus passes unchanged.
package sacc_pkg;
    typedef enum logic [1:0] {
        ACC_OFF     = 2'b00,
        ACC_FLOOR   = 2'b01,
        ACC_SIGNED  = 2'b10,
        ACC_SIG_CMP = 2'b11
    } acc_mode_e;
endpackage

// File: rtl/sacc_next.sv
`timescale 1ns/1ps
// Module: sacc_next
// Works out the next value of the running total from the current total,
// the mode and the strobed sample. Purely combinational.
// Assumes SAMPLE_W < ACC_W, so the magnitude of the most negative sample fits.
module sacc_next
    import sacc_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int ACC_W    = 32
) (
    input  logic [1:0]          mode,
    input  logic                valid,
    input  logic [SAMPLE_W-1:0] sample,
    input  logic [ACC_W-1:0]    total,
    output logic [ACC_W-1:0]    total_nxt
);
    localparam int EXT_W = ACC_W - SAMPLE_W;

    logic [ACC_W-1:0] sample_ext;
    logic [ACC_W-1:0] sample_mag;
    logic             sample_neg;
    logic             floor_hit;

    // Sign-extend the sample and form its magnitude.
    always_comb begin
        sample_neg = sample[SAMPLE_W-1];
        sample_ext = {{EXT_W{sample_neg}}, sample};
        sample_mag = sample_neg ? (~sample_ext + 1'b1) : sample_ext;
        floor_hit  = sample_neg && (total < sample_mag);
    end

    // Select the update rule that the mode asks for.
    always_comb begin
        total_nxt = total;
        unique case (acc_mode_e'(mode))
            ACC_OFF: total_nxt = '0;
            ACC_FLOOR: begin
                if (valid) begin
                    if (!sample_neg)    total_nxt = total + sample_ext;
                    else if (floor_hit) total_nxt = '0;
                    else                total_nxt = total - sample_mag;
                end
            end
            ACC_SIGNED, ACC_SIG_CMP: begin
                if (valid) total_nxt = total + sample_ext;
            end
            default: total_nxt = total;
        endcase
    end
endmodule

// File: rtl/sacc_cmp.sv
`timescale 1ns/1ps
// Module: sacc_cmp
// Signed threshold comparator with an arm flag. It gives one registered pulse
// when the total first meets the threshold, and it re-arms once the total falls
// below the threshold or the comparator is disabled.
// Assumes total and threshold are two's-complement values of the same width.
module sacc_cmp #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [ACC_W-1:0] total,
    input  logic [ACC_W-1:0] threshold,
    output logic             irq
);
    logic above;
    logic armed;

    // Signed compare of the registered total against the threshold.
    always_comb begin
        above = $signed(total) >= $signed(threshold);
    end

    // Arm-flag and pulse register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b1;
            irq   <= 1'b0;
        end else if (!enable) begin
            armed <= 1'b1;
            irq   <= 1'b0;
        end else begin
            irq <= armed && above;
            if (!above)          armed <= 1'b1;
            else if (armed)      armed <= 1'b0;
        end
    end

    // R6: a pulse is never two cycles long
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    // R6: a pulse follows an edge at which the comparator was enabled and the total met the threshold
    a_r6_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && above && armed) |=> irq);
    // R7: no pulse while disarmed
    a_r7_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed) |=> !irq);
endmodule

// File: rtl/sample_accum.sv
`timescale 1ns/1ps
// Module: sample_accum (top)
// Running total of signed conversion samples with four modes, plus a signed
// threshold comparator that is active in the last mode.
// Assumes smp_valid is a one-cycle strobe that is synchronous to clk.
module sample_accum
    import sacc_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int ACC_W    = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic [1:0]          mode,
    input  logic [ACC_W-1:0]    threshold,
    output logic [ACC_W-1:0]    acc_total,
    output logic                cmp_irq
);
    logic [ACC_W-1:0] total_q;
    logic [ACC_W-1:0] total_d;
    logic             cmp_en;

    sacc_next #(.SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W)) u_next (
        .mode      (mode),
        .valid     (smp_valid),
        .sample    (smp_data),
        .total     (total_q),
        .total_nxt (total_d)
    );

    // Comparator is enabled only in the comparator mode.
    always_comb begin
        cmp_en = (acc_mode_e'(mode) == ACC_SIG_CMP);
    end

    sacc_cmp #(.ACC_W(ACC_W)) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (cmp_en),
        .total     (total_q),
        .threshold (threshold),
        .irq       (cmp_irq)
    );

    // Total register.
    always_ff @(posedge clk) begin
        if (!rst_n) total_q <= '0;
        else        total_q <= total_d;
    end

    assign acc_total = total_q;

    // R2: off mode leaves zero after the edge
    a_r2_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00) |=> (acc_total == '0));
    // R2: no interrupt after an edge in off mode
    a_r2_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00) |=> !cmp_irq);
    // R8: no strobe, no change
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_valid && mode != 2'b00) |=> $stable(acc_total));
    // R3: a negative sample in floor mode never raises the total
    a_r3_floor_down: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01 && smp_valid && smp_data[SAMPLE_W-1])
        |=> (acc_total <= $past(acc_total)));
    // R6: pulses only after an edge in comparator mode
    a_r6_mode_only: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_irq |-> ($past(mode) == 2'b11));
endmodule

// File: tb/sim_sample_accum.sv
`timescale 1ns/1ps
// Bench: sweeps all four modes against an arithmetic model of the total and
// of the comparator arm flag, including floor, signed wrap and re-arm cases.
module sim_sample_accum;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_data = '0;
    logic [1:0]  mode = 2'b00;
    logic [31:0] threshold = '0;
    logic [31:0] acc_total;
    logic        cmp_irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [31:0] m_acc   = '0;
    logic        m_armed = 1'b1;
    logic        m_irq   = 1'b0;

    always #4 clk = ~clk;

    sample_accum u0 (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .mode(mode), .threshold(threshold), .acc_total(acc_total), .cmp_irq(cmp_irq)
    );

    task automatic check(input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // Apply one cycle of stimulus at a falling edge, model the rising edge,
    // and compare at the following falling edge.
    task automatic step(input logic v, input logic [15:0] d, input logic [1:0] m,
                        input string tag);
        logic        above;
        logic [31:0] ext;
        logic [31:0] mag;
        smp_valid = v;
        smp_data  = d;
        mode      = m;
        @(posedge clk);
        above = $signed(m_acc) >= $signed(threshold);
        if (m == 2'b11) begin
            m_irq = m_armed && above;
            if (!above) m_armed = 1'b1;
            else        m_armed = 1'b0;
        end else begin
            m_irq   = 1'b0;
            m_armed = 1'b1;
        end
        ext = {{16{d[15]}}, d};
        mag = d[15] ? (32'd0 - ext) : ext;
        case (m)
            2'b00: m_acc = '0;
            2'b01: if (v) begin
                if (!d[15])          m_acc = m_acc + ext;
                else if (m_acc < mag) m_acc = '0;
                else                 m_acc = m_acc - mag;
            end
            default: if (v) m_acc = m_acc + ext;
        endcase
        @(negedge clk);
        check(tag, acc_total, m_acc);
        check({tag, " irq"}, {31'd0, cmp_irq}, {31'd0, m_irq});
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        mode = 2'b10; smp_valid = 1'b1; smp_data = 16'h1234;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 total", acc_total, 32'd0);
        check("R1 irq", {31'd0, cmp_irq}, 32'd0);
        rst_n = 1'b1;
        threshold = 32'h7FFF_FFFF;

        // R2: off mode ignores samples
        for (int i = 0; i < 16; i++) step(1'b1, 16'(i * 4099), 2'b00, "R2 off");

        // R3: floor mode sweep over the full sample range
        for (int i = 0; i < 256; i++) step(1'b1, 16'(-32768 + i * 257), 2'b01, "R3 sweep");
        for (int i = 0; i < 200; i++) step(i % 3 != 0, 16'(i * 7919), 2'b01, "R3 mixed");
        step(1'b1, 16'd5, 2'b00, "R2 clear");
        step(1'b1, 16'd100, 2'b01, "R3 add");
        step(1'b1, 16'hFF9C, 2'b01, "R3 exact zero");
        step(1'b1, 16'd10, 2'b01, "R3 add");
        step(1'b1, 16'h8000, 2'b01, "R3 floor");
        step(1'b0, 16'd77, 2'b01, "R8 hold");

        // R4: signed mode sweep, going negative
        step(1'b0, 16'd0, 2'b00, "R2 clear");
        for (int i = 0; i < 256; i++) step(1'b1, 16'(32767 - i * 257), 2'b10, "R4 sweep");
        for (int i = 0; i < 64; i++) step(1'b1, 16'h8000, 2'b10, "R4 negative");
        step(1'b0, 16'h7FFF, 2'b10, "R8 hold");

        // R4: wrap past the positive signed range
        step(1'b0, 16'd0, 2'b00, "R2 clear");
        for (int i = 0; i < 65540; i++) step(1'b1, 16'h7FFF, 2'b10, "R4 wrap");
        check("R4 wrapped sign", {31'd0, acc_total[31]}, 32'd1);

        // R5/R6/R7: comparator mode
        step(1'b0, 16'd0, 2'b00, "R2 clear");
        threshold = 32'd1000;
        for (int i = 0; i < 8; i++) step(1'b1, 16'd300, 2'b11, "R6 climb");
        for (int i = 0; i < 6; i++) step(1'b0, 16'd0, 2'b11, "R7 stay above");
        step(1'b1, 16'hF830, 2'b11, "R7 drop");
        step(1'b0, 16'd0, 2'b11, "R7 rearm");
        for (int i = 0; i < 8; i++) step(1'b1, 16'd400, 2'b11, "R6 second");
        threshold = 32'hFFFF_F000;
        step(1'b0, 16'd0, 2'b00, "R2 clear");
        for (int i = 0; i < 40; i++) step(1'b1, 16'(-2000 + (i % 5) * 900), 2'b11, "R5 signed thr");
        step(1'b1, 16'd1, 2'b10, "R6 leave mode");
        step(1'b0, 16'd0, 2'b11, "R7 rearm via mode");
        for (int i = 0; i < 300; i++) begin
            threshold = 32'(i * 37) - 32'd2000;
            step(i % 2 == 0, 16'(i * 613), 2'b11, "R6 sweep");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule